// File: doc/BRIEF.md
# Timestamped Header Block Batcher

This block gathers captured header records into fixed-size blocks so a consumer can handle them in batches instead of one at a time. Records arrive on a valid/ready input. The first record of a block takes a buffer slot index from the head of a free-slot queue. It also captures the current value of a free-running 64-bit cycle counter. That single value becomes the timestamp for the whole block. Each record is written out on a simple write port, tagged with the slot index and its position inside the slot.

When a block reaches its configured size, the block's slot index and timestamp are placed in a completed-block queue for the consumer to pop. If that queue has no room, the block is held and the input stalls. If no free slot is available when a block would start, records are still accepted but are discarded and counted. A periodic interrupt tells the consumer to return free slots before the supply runs out.

The block size can be changed at run time. Only sizes that divide the maximum block size evenly are accepted.

Top module: `hb_batcher`

## Requirements
- R1: After reset, rec_ready is 1, done_valid is 0, irq is 0, drop_cnt is 0 and blk_size is 128.
- R2: A write with cfg_we loads cfg_size into blk_size only if exactly one bit of cfg_size is set, which means the value is 1, 2, 4, 8, 16, 32, 64 or 128. Any other value, including 0, is ignored and blk_size keeps its previous value.
- R3: Each accepted record that is not dropped raises wr_en in the same cycle. It is written to position wr_pos of slot wr_slot. Positions run 0, 1, ..., blk_size-1 within one slot. The slot is the head of the free queue, taken when the record at position 0 is accepted.
- R4: The timestamp counter is 0 while reset is asserted and increases by 1 on every clock edge after reset is released. A block's timestamp is the counter value in the cycle its position-0 record is accepted.
- R5: Once blk_size records have been written, the block's {slot, timestamp} pair is appended to the completed-block queue. The pair appears on done_slot/done_ts with done_valid from the next cycle on. Entries leave the queue in completion order, one per cycle in which done_pop is high.
- R6: A record accepted while no block is open and the free queue is empty is dropped. No write happens, rec_ready stays 1, and drop_cnt increases by 1, saturating at its maximum.
- R7: If the completed-block queue is full when a block completes, the block is held and rec_ready is 0. rec_ready returns to 1 one cycle after the block has been appended, which happens in the first cycle the queue has room.
- R8: irq is a one-cycle pulse in the cycle after every 128th accepted record, counting both written and dropped records.
- R9: The free queue and the completed-block queue each hold 256 entries. free_full is 1 after 256 free slots have been pushed and none taken. The completed-block queue stores 256 blocks before a completing block is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Header record offered |
| rec_ready | output | 1 | Block can take a record this cycle |
| rec_data | input | 32 | Header record contents |
| wr_en | output | 1 | Record write strobe |
| wr_slot | output | 8 | Slot index of the write |
| wr_pos | output | 7 | Position of the record inside the slot |
| wr_data | output | 32 | Record being written |
| cfg_we | input | 1 | Block-size write strobe |
| cfg_size | input | 8 | Requested block size |
| blk_size | output | 8 | Block size in force |
| free_push | input | 1 | Return a free slot |
| free_slot | input | 8 | Slot index returned |
| free_full | output | 1 | Free queue cannot take more |
| done_valid | output | 1 | Completed block at queue head |
| done_slot | output | 8 | Slot of the head block |
| done_ts | output | 64 | Timestamp of the head block |
| done_pop | input | 1 | Remove the head block |
| irq | output | 1 | Service interrupt pulse |
| drop_cnt | output | 16 | Dropped record count |

## Verification
The batching path is driven at each accepted block size, from one record per block to 128. It is also driven with rejected size values (a non-power of two and zero) sent between valid ones. A rejected value would otherwise shorten or lengthen the next block, so the length of the following block shows that the previous size is still in force.

A long run with no free slots separates dropping from writing and places the interrupt exactly on the 128th record. Filling the completed-block queue with 256 one-record blocks, then completing one more, shows three things: the stall, its release after a pop, and that the held block comes out last with its own slot and timestamp.

// File: rtl/hb_pkg.sv
package hb_pkg;
    localparam int unsigned Q_DEPTH = 256;
    localparam int unsigned SLOT_W  = $clog2(Q_DEPTH);
    localparam int unsigned TS_W    = 64;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [TS_W-1:0]   ts;
    } blk_ent_t;
endpackage

// File: rtl/hb_fifo.sv
module hb_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        full    = (st_q.cnt == CW'(DEPTH));
        empty   = (st_q.cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        head    = mem[st_q.rp];
        st_d    = st_q;
        if (do_push) st_d.wp = st_q.wp + 1'b1;
        if (do_pop)  st_d.rp = st_q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= din;
    end
endmodule

// File: rtl/hb_tsc.sv
module hb_tsc #(
    parameter int unsigned TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] value
);
    logic [TS_W-1:0] cnt_d, cnt_q;

    always_comb cnt_d = cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value = cnt_q;
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
    import hb_pkg::*;
#(
    parameter int unsigned MAX_BLK   = 128,
    parameter int unsigned DROP_W    = 16,
    parameter int unsigned IRQ_EVERY = 128,
    localparam int unsigned POS_W    = $clog2(MAX_BLK),
    localparam int unsigned SZ_W     = POS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    output logic              rec_ready,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [POS_W-1:0]  wr_pos,
    input  logic              cfg_we,
    input  logic [SZ_W-1:0]   cfg_size,
    output logic [SZ_W-1:0]   blk_size,
    input  logic [TS_W-1:0]   tsc,
    input  logic              free_empty,
    input  logic [SLOT_W-1:0] free_head,
    output logic              free_pop,
    input  logic              done_full,
    output logic              done_push,
    output blk_ent_t          done_ent,
    output logic              irq,
    output logic [DROP_W-1:0] drop_cnt
);
    localparam int unsigned IC_W = $clog2(IRQ_EVERY + 1);

    typedef struct packed {
        logic              open;
        logic              pend;
        logic [SLOT_W-1:0] slot;
        logic [POS_W-1:0]  pos;
        logic [TS_W-1:0]   ts;
        logic [SZ_W-1:0]   size;
        logic [DROP_W-1:0] drops;
        logic [IC_W-1:0]   icnt;
        logic              irq;
    } st_t;

    st_t  st_d, st_q;
    logic acc, last, size_ok;

    always_comb begin
        st_d      = st_q;
        st_d.irq  = 1'b0;
        rec_ready = !st_q.pend;
        acc       = rec_valid && !st_q.pend;
        size_ok   = ($countones(cfg_size) == 1) && (cfg_size <= SZ_W'(MAX_BLK));
        free_pop  = 1'b0;
        wr_en     = 1'b0;
        wr_slot   = st_q.slot;
        wr_pos    = st_q.pos;
        done_push = 1'b0;
        last      = 1'b0;
        done_ent  = '{slot: st_q.slot, ts: st_q.ts};

        if (cfg_we && size_ok) st_d.size = cfg_size;

        if (st_q.pend) begin
            if (!done_full) begin
                done_push = 1'b1;
                st_d.pend = 1'b0;
                st_d.open = 1'b0;
                st_d.pos  = '0;
            end
        end else if (acc) begin
            if (st_q.open || !free_empty) begin
                wr_en = 1'b1;
                if (!st_q.open) begin
                    free_pop  = 1'b1;
                    wr_slot   = free_head;
                    wr_pos    = '0;
                    st_d.open = 1'b1;
                    st_d.slot = free_head;
                    st_d.ts   = tsc;
                end
                last     = (SZ_W'(wr_pos) + 1'b1) >= st_q.size;
                done_ent = '{slot: wr_slot, ts: st_d.ts};
                if (last) begin
                    st_d.pos = wr_pos;
                    if (!done_full) begin
                        done_push = 1'b1;
                        st_d.open = 1'b0;
                        st_d.pos  = '0;
                    end else begin
                        st_d.pend = 1'b1;
                    end
                end else begin
                    st_d.pos = wr_pos + 1'b1;
                end
            end else if (st_q.drops != '1) begin
                st_d.drops = st_q.drops + 1'b1;
            end

            if (st_q.icnt == IC_W'(IRQ_EVERY - 1)) begin
                st_d.icnt = '0;
                st_d.irq  = 1'b1;
            end else begin
                st_d.icnt = st_q.icnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.size <= SZ_W'(MAX_BLK);
        end else begin
            st_q <= st_d;
        end
    end

    assign blk_size = st_q.size;
    assign irq      = st_q.irq;
    assign drop_cnt = st_q.drops;
endmodule

// File: rtl/hb_batcher.sv
module hb_batcher
    import hb_pkg::*;
#(
    parameter int unsigned REC_W     = 32,
    parameter int unsigned MAX_BLK   = 128,
    parameter int unsigned DROP_W    = 16,
    parameter int unsigned IRQ_EVERY = 128,
    localparam int unsigned POS_W    = $clog2(MAX_BLK),
    localparam int unsigned SZ_W     = POS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    output logic              rec_ready,
    input  logic [REC_W-1:0]  rec_data,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [POS_W-1:0]  wr_pos,
    output logic [REC_W-1:0]  wr_data,
    input  logic              cfg_we,
    input  logic [SZ_W-1:0]   cfg_size,
    output logic [SZ_W-1:0]   blk_size,
    input  logic              free_push,
    input  logic [SLOT_W-1:0] free_slot,
    output logic              free_full,
    output logic              done_valid,
    output logic [SLOT_W-1:0] done_slot,
    output logic [TS_W-1:0]   done_ts,
    input  logic              done_pop,
    output logic              irq,
    output logic [DROP_W-1:0] drop_cnt
);
    logic [TS_W-1:0]   tsc;
    logic              free_empty, free_pop;
    logic [SLOT_W-1:0] free_head;
    logic              done_full, done_push, done_empty;
    blk_ent_t          done_ent, done_head;

    hb_tsc #(.TS_W(TS_W)) u_tsc (
        .clk   (clk),
        .rst_n (rst_n),
        .value (tsc)
    );

    hb_fifo #(.WIDTH(SLOT_W), .DEPTH(Q_DEPTH)) u_free_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (free_push),
        .din   (free_slot),
        .pop   (free_pop),
        .head  (free_head),
        .empty (free_empty),
        .full  (free_full)
    );

    hb_fifo #(.WIDTH($bits(blk_ent_t)), .DEPTH(Q_DEPTH)) u_done_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (done_push),
        .din   (done_ent),
        .pop   (done_pop),
        .head  (done_head),
        .empty (done_empty),
        .full  (done_full)
    );

    hb_ctrl #(
        .MAX_BLK   (MAX_BLK),
        .DROP_W    (DROP_W),
        .IRQ_EVERY (IRQ_EVERY)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rec_valid  (rec_valid),
        .rec_ready  (rec_ready),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .wr_pos     (wr_pos),
        .cfg_we     (cfg_we),
        .cfg_size   (cfg_size),
        .blk_size   (blk_size),
        .tsc        (tsc),
        .free_empty (free_empty),
        .free_head  (free_head),
        .free_pop   (free_pop),
        .done_full  (done_full),
        .done_push  (done_push),
        .done_ent   (done_ent),
        .irq        (irq),
        .drop_cnt   (drop_cnt)
    );

    assign wr_data    = rec_data;
    assign done_valid = !done_empty;
    assign done_slot  = done_head.slot;
    assign done_ts    = done_head.ts;
endmodule

// File: rtl/hb_batcher_chk.sv
module hb_batcher_chk #(
    parameter int unsigned SZ_W   = 8,
    parameter int unsigned DROP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rec_valid,
    input logic              rec_ready,
    input logic              wr_en,
    input logic              cfg_we,
    input logic [SZ_W-1:0]   cfg_size,
    input logic [SZ_W-1:0]   blk_size,
    input logic              irq,
    input logic [DROP_W-1:0] drop_cnt,
    input logic              done_full
);
    AST_WR_NEEDS_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (rec_valid && rec_ready)); // R3

    AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_ready && !wr_en && drop_cnt != '1)
        |=> (drop_cnt == $past(drop_cnt) + 1'b1)); // R6

    AST_SIZE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(blk_size) == 1); // R2

    AST_BAD_CFG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && $countones(cfg_size) != 1) |=> $stable(blk_size)); // R2

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8

    AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rec_ready) |-> $past(done_full)); // R7

    AST_NO_WRITE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_ready |-> !wr_en); // R7
endmodule

bind hb_batcher hb_batcher_chk #(.SZ_W(SZ_W), .DROP_W(DROP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .wr_en     (wr_en),
    .cfg_we    (cfg_we),
    .cfg_size  (cfg_size),
    .blk_size  (blk_size),
    .irq       (irq),
    .drop_cnt  (drop_cnt),
    .done_full (done_full)
);

// File: tb/tb_hb_batcher.sv
module tb_hb_batcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rec_valid = 1'b0;
    logic        rec_ready;
    logic [31:0] rec_data = '0;
    logic        wr_en;
    logic [7:0]  wr_slot;
    logic [6:0]  wr_pos;
    logic [31:0] wr_data;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_size = '0;
    logic [7:0]  blk_size;
    logic        free_push = 1'b0;
    logic [7:0]  free_slot = '0;
    logic        free_full;
    logic        done_valid;
    logic [7:0]  done_slot;
    logic [63:0] done_ts;
    logic        done_pop = 1'b0;
    logic        irq;
    logic [15:0] drop_cnt;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    logic [63:0] tb_cyc = '0;

    hb_batcher dut (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_data(rec_data), .wr_en(wr_en), .wr_slot(wr_slot), .wr_pos(wr_pos),
        .wr_data(wr_data), .cfg_we(cfg_we), .cfg_size(cfg_size), .blk_size(blk_size),
        .free_push(free_push), .free_slot(free_slot), .free_full(free_full),
        .done_valid(done_valid), .done_slot(done_slot), .done_ts(done_ts),
        .done_pop(done_pop), .irq(irq), .drop_cnt(drop_cnt)
    );

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n) tb_cyc <= tb_cyc + 1;

    // size vectors: requested value, size expected in force afterwards
    localparam logic [7:0] CFG_V [0:6] = '{8'd4, 8'd3, 8'd0, 8'd1, 8'd6, 8'd32, 8'd128};
    localparam logic [7:0] EXP_V [0:6] = '{8'd4, 8'd4, 8'd4, 8'd1, 8'd1, 8'd32, 8'd128};

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic give_free(input logic [7:0] s);
        free_slot = s; free_push = 1'b1;
        @(negedge clk);
        free_push = 1'b0;
    endtask

    task automatic set_size(input logic [7:0] v);
        cfg_size = v; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] ts_exp;
        logic        bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(rec_ready == 1'b1, "R1 ready", rec_ready, 1);
        check(done_valid == 1'b0, "R1 done_valid", done_valid, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(drop_cnt == 16'd0, "R1 drop_cnt", drop_cnt, 0);
        check(blk_size == 8'd128, "R1 blk_size", blk_size, 128);

        // R6 and R8: 128 records with no free slot
        bad = 1'b0;
        for (int i = 0; i < 128; i++) begin
            rec_valid = 1'b1; rec_data = 32'(i);
            #1;
            if (wr_en || !rec_ready) bad = 1'b1;
            if (i > 0 && irq) bad = 1'b1;
            @(negedge clk);
        end
        rec_valid = 1'b0;
        check(!bad, "R6 no write, ready high, no early irq (R8)", bad, 0);
        check(irq == 1'b1, "R8 irq after 128th record", irq, 1);
        check(drop_cnt == 16'd128, "R6 drop count", drop_cnt, 128);
        @(negedge clk);
        check(irq == 1'b0, "R8 irq one cycle", irq, 0);

        // R2 R3 R4 R5: walk the size vectors
        for (int v = 0; v < 7; v++) begin
            give_free(8'(20 + v));
            set_size(CFG_V[v]);
            check(blk_size == EXP_V[v], "R2 blk_size after cfg", blk_size, EXP_V[v]);
            ts_exp = '0;
            bad = 1'b0;
            for (int k = 0; k < int'(EXP_V[v]); k++) begin
                rec_valid = 1'b1; rec_data = 32'(1000 * v + k);
                #1;
                if (k == 0) ts_exp = tb_cyc;
                if (!wr_en || wr_slot != 8'(20 + v) || wr_pos != 7'(k) ||
                    wr_data != 32'(1000 * v + k)) bad = 1'b1;
                if (k == 0) check(done_valid == 1'b0, "R5 no early completion",
                                  done_valid, 0);
                @(negedge clk);
            end
            rec_valid = 1'b0;
            check(!bad, "R3 write slot/position sequence", bad, 0);
            check(done_valid == 1'b1, "R5 block completed", done_valid, 1);
            check(done_slot == 8'(20 + v), "R5 done slot", done_slot, 20 + v);
            check(done_ts == ts_exp, "R4 block timestamp", done_ts, ts_exp);
            done_pop = 1'b1;
            @(negedge clk);
            done_pop = 1'b0;
            check(done_valid == 1'b0, "R5 single entry per block", done_valid, 0);
        end

        // R9 and R7: fill both queues, then stall
        set_size(8'd1);
        for (int i = 0; i < 256; i++) begin
            check(free_full == 1'b0, "R9 free not yet full", free_full, 0);
            give_free(8'(i));
        end
        check(free_full == 1'b1, "R9 free full at 256", free_full, 1);
        bad = 1'b0;
        for (int i = 0; i < 256; i++) begin
            rec_valid = 1'b1;
            #1;
            if (!rec_ready || !wr_en || wr_slot != 8'(i)) bad = 1'b1;
            @(negedge clk);
        end
        rec_valid = 1'b0;
        check(!bad, "R9 256 blocks taken without stall", bad, 0);
        give_free(8'hAA);
        rec_valid = 1'b1;
        #1;
        ts_exp = tb_cyc;
        @(negedge clk);
        rec_valid = 1'b0;
        check(rec_ready == 1'b0, "R7 stall when queue full", rec_ready, 0);
        repeat (3) @(negedge clk);
        check(rec_ready == 1'b0, "R7 stall held", rec_ready, 0);
        check(done_slot == 8'd0, "R5 oldest block first", done_slot, 0);
        done_pop = 1'b1;
        @(negedge clk);
        done_pop = 1'b0;
        check(rec_ready == 1'b0, "R7 ready still low during append", rec_ready, 0);
        @(negedge clk);
        check(rec_ready == 1'b1, "R7 ready after append", rec_ready, 1);
        bad = 1'b0;
        for (int i = 1; i < 256; i++) begin
            if (!done_valid || done_slot != 8'(i)) bad = 1'b1;
            done_pop = 1'b1;
            @(negedge clk);
        end
        done_pop = 1'b0;
        check(!bad, "R5 completion order", bad, 0);
        check(done_valid && done_slot == 8'hAA, "R7 held block slot", done_slot, 8'hAA);
        check(done_ts == ts_exp, "R4 held block timestamp", done_ts, ts_exp);
        done_pop = 1'b1;
        @(negedge clk);
        done_pop = 1'b0;
        check(done_valid == 1'b0, "R9 queue drained", done_valid, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule